// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the register face of a command/response-buffer style security-module interface. A host reaches it through a plain 32-bit register bus with a byte address and byte enables. Writes to the control registers are not stored as data. They act as strobes, and each strobe takes effect only when the written value matches one exact code. Through these strobes the host moves the module between idle and ready, launches a command, requests a cancel and claims the single supported locality.

A launch sets a start bit, which the host can read back, and sends a one-cycle command-request pulse to a backend engine. The start bit stays set until the engine returns a completion strobe. That strobe clears the bit and, if its status is nonzero, sets a sticky fatal-error flag. A cancel pulse goes out only while a command is outstanding, so at most one command is ever in flight.

The block also returns constant registers: an interface-identification pair and four buffer descriptors that give the size and address of the command and response areas. The data buffer and the engine are outside the block.

Top module: `crb_regif`

## Requirements
- R1: After synchronous active-low reset the status register (offset 0x24) reads 0x2 (idle bit 1 set, fatal bit 0 clear), the start register (0x2C) reads 0, both locality registers read 0, and neither engine pulse is asserted.
- R2: A write of exactly 1 to the request register (0x20) clears the idle bit. A write of exactly 2 sets it. Any other written value leaves the status register unchanged.
- R3: A write of exactly 1 to the start register while its bit 0 is clear sets that bit and produces exactly one `eng_cmd_req` pulse in the cycle after the write. While the bit is set, such a write produces no pulse.
- R4: A write of exactly 1 to the cancel register (0x28) produces one `eng_cancel` pulse in the cycle after the write, but only if the start bit is set. Otherwise the write has no visible effect.
- R5: `eng_done` while the start bit is set clears the bit. If `eng_status` is nonzero at the same time, status bit 0 (fatal) is set and stays set until reset. `eng_done` with the start bit clear changes nothing.
- R6: A write of exactly 1 to the locality-control register (0x04) makes the locality-status register (0x08) read 0x1 (granted bit 0 set, seized bit 1 clear) and the locality-state register (0x00) read 0x3 (valid bit 0 and assigned bit 1 set). Any other value, including 2 and 8, is ignored.
- R7: A read returns the aligned 32-bit register shifted right by 8 times the low two address bits.
- R8: The identification register at 0x10 reads 0x00025811. Its fields are: type [3:0]=1, version [7:4]=1, locality cap [8]=0, idle-bypass cap [9]=0, transfer size [12:11]=3, FIFO cap [13]=0, CRB cap [14]=1, selector [18:17]=1, revision [31:24]=0. The register at 0x14 reads the `VENDOR_ID` parameter in bits [15:0].
- R9: The command size (0x30) and response size (0x38) read `WINDOW_SIZE - BUF_OFFSET`. The command address (0x34) and response address (0x3C) read `BASE_ADDR + BUF_OFFSET`.
- R10: The written value is the write data with every byte whose enable is low forced to zero. A write with nonzero low address bits, or to a read-only or unlisted offset, changes nothing. Write-only and unlisted offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| eng_cmd_req | output | 1 | One-cycle command launch pulse |
| eng_cancel | output | 1 | One-cycle cancel pulse |
| eng_done | input | 1 | Completion strobe from the engine |
| eng_status | input | ERR_W | Completion status, nonzero means failure |

## Verification
The bench builds the block with an 8-bit address and an 8-bit status. The base is 0xFED40000, the buffer offset 0x80, the window 0x1000 and the vendor code 0x1AB5, so the descriptors must read 0xF80 and 0xFED40080. The 8-bit address lets random accesses reach every listed, unlisted and misaligned byte offset of the window. Together with random byte enables and near-miss values such as 3 and 2 sent to strobe registers, this exercises the exact-match decode. Completions arrive at random while the start bit is both set and clear, which covers the stray-completion and cancel-when-idle cases.

// File: rtl/crb_regif_pkg.sv
// Package: shared offsets, field positions and types for the command-response
// buffer control block. Assumes the register window is at least 64 bytes.
package crb_regif_pkg;

    // Word offsets of the register map (byte addresses, word aligned)
    localparam logic [7:0] OFS_LOC_STATE = 8'h00;
    localparam logic [7:0] OFS_LOC_CTRL  = 8'h04;
    localparam logic [7:0] OFS_LOC_STS   = 8'h08;
    localparam logic [7:0] OFS_ID_LO     = 8'h10;
    localparam logic [7:0] OFS_ID_HI     = 8'h14;
    localparam logic [7:0] OFS_REQ       = 8'h20;
    localparam logic [7:0] OFS_STS       = 8'h24;
    localparam logic [7:0] OFS_CANCEL    = 8'h28;
    localparam logic [7:0] OFS_START     = 8'h2C;
    localparam logic [7:0] OFS_CMD_SIZE  = 8'h30;
    localparam logic [7:0] OFS_CMD_ADDR  = 8'h34;
    localparam logic [7:0] OFS_RSP_SIZE  = 8'h38;
    localparam logic [7:0] OFS_RSP_ADDR  = 8'h3C;

    // Exact strobe codes
    localparam logic [31:0] CODE_READY   = 32'd1;
    localparam logic [31:0] CODE_IDLE    = 32'd2;
    localparam logic [31:0] CODE_INVOKE  = 32'd1;
    localparam logic [31:0] CODE_CLAIM   = 32'd1;

    // Decoded write strobes, one per command register
    typedef struct packed {
        logic req;
        logic start;
        logic cancel;
        logic locctl;
    } wr_hit_t;

    // Locality flags as seen by the read path
    typedef struct packed {
        logic granted;
        logic seized;
        logic assigned;
        logic reg_valid;
    } loc_flags_t;

    // Build the fixed identification word from its fields
    function automatic logic [31:0] build_id_lo();
        logic [31:0] w;
        w        = 32'h0;
        w[3:0]   = 4'd1;   // interface type: buffer interface active
        w[7:4]   = 4'd1;   // interface version
        w[8]     = 1'b0;   // locality 0 only
        w[9]     = 1'b0;   // no idle bypass
        w[12:11] = 2'b11;  // 64-byte transfers
        w[13]    = 1'b0;   // FIFO not supported
        w[14]    = 1'b1;   // buffer interface supported
        w[18:17] = 2'd1;   // selector: buffer interface
        w[31:24] = 8'd0;   // revision
        return w;
    endfunction

endpackage

// File: rtl/crb_wr_decode.sv
// Write decoder: masks write data by byte enables and raises one strobe per
// command register. Assumes writes are only honoured at word-aligned offsets.
module crb_wr_decode
    import crb_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output wr_hit_t           hits,
    output logic [31:0]       wval
);

    logic wen;

    // Zero every byte whose enable is low
    for (genvar i = 0; i < 4; i++) begin : g_bytemask
        assign wval[8*i +: 8] = bus_be[i] ? bus_wdata[8*i +: 8] : 8'h00;
    end

    // Aligned write qualifier
    assign wen = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);

    // Per-register strobe decode
    always_comb begin
        hits.req    = wen && (bus_addr == ADDR_W'(OFS_REQ));
        hits.start  = wen && (bus_addr == ADDR_W'(OFS_START));
        hits.cancel = wen && (bus_addr == ADDR_W'(OFS_CANCEL));
        hits.locctl = wen && (bus_addr == ADDR_W'(OFS_LOC_CTRL));
    end

endmodule

// File: rtl/crb_ctrl.sv
// Control core: idle flag, sticky fatal flag, self-clearing start bit and the
// two engine pulses. Assumes the engine returns one completion per launch.
module crb_ctrl
    import crb_regif_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_hit_t          hits,
    input  logic [31:0]      wval,
    input  logic             eng_done,
    input  logic [ERR_W-1:0] eng_status,
    output logic             idle_q,
    output logic             fatal_q,
    output logic             start_q,
    output logic             cmd_req_q,
    output logic             cancel_q
);

    logic launch;
    logic abort;
    logic finish;

    assign launch = hits.start && (wval == CODE_INVOKE) && !start_q;
    assign abort  = hits.cancel && (wval == CODE_INVOKE) && start_q;
    assign finish = eng_done && start_q;

    // Idle flag follows exact ready / go-idle codes
    always_ff @(posedge clk) begin
        if (!rst_n)                                  idle_q <= 1'b1;
        else if (hits.req && (wval == CODE_READY))   idle_q <= 1'b0;
        else if (hits.req && (wval == CODE_IDLE))    idle_q <= 1'b1;
    end

    // Start bit: set by launch, cleared by completion
    always_ff @(posedge clk) begin
        if (!rst_n)      start_q <= 1'b0;
        else if (launch) start_q <= 1'b1;
        else if (finish) start_q <= 1'b0;
    end

    // Sticky fatal flag on failed completion
    always_ff @(posedge clk) begin
        if (!rst_n)                                fatal_q <= 1'b0;
        else if (finish && (eng_status != '0))     fatal_q <= 1'b1;
    end

    // One-cycle engine pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_req_q <= 1'b0;
            cancel_q  <= 1'b0;
        end else begin
            cmd_req_q <= launch;
            cancel_q  <= abort;
        end
    end

endmodule

// File: rtl/crb_loc.sv
// Locality tracker for the single supported locality. Assumes only the claim
// code has an effect; release and establishment-reset codes are accepted idly.
module crb_loc
    import crb_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  wr_hit_t     hits,
    input  logic [31:0] wval,
    output loc_flags_t  flags
);

    logic claim;
    assign claim = hits.locctl && (wval == CODE_CLAIM);

    // Grant and mark valid on a claim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (claim) begin
            flags.granted   <= 1'b1;
            flags.seized    <= 1'b0;
            flags.assigned  <= 1'b1;
            flags.reg_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/crb_rd_mux.sv
// Read path: selects the aligned word and shifts it by the byte offset.
// Assumes a combinational read answered in the cycle of the request.
module crb_rd_mux
    import crb_regif_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [31:0] BUF_SIZE  = 32'hF80,
    parameter logic [31:0] BUF_ADDR  = 32'hFED40080
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              idle_q,
    input  logic              fatal_q,
    input  logic              start_q,
    input  loc_flags_t        flags,
    output logic [31:0]       bus_rdata
);

    localparam logic [31:0] ID_LO = build_id_lo();

    logic [ADDR_W-1:0] word_addr;
    logic [31:0]       word;

    assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};

    // Aligned register select
    always_comb begin
        word = 32'h0;
        if (word_addr == ADDR_W'(OFS_LOC_STATE)) word = {30'h0, flags.assigned, flags.reg_valid};
        if (word_addr == ADDR_W'(OFS_LOC_STS))   word = {30'h0, flags.seized, flags.granted};
        if (word_addr == ADDR_W'(OFS_ID_LO))     word = ID_LO;
        if (word_addr == ADDR_W'(OFS_ID_HI))     word = {16'h0, VENDOR_ID};
        if (word_addr == ADDR_W'(OFS_STS))       word = {30'h0, idle_q, fatal_q};
        if (word_addr == ADDR_W'(OFS_START))     word = {31'h0, start_q};
        if (word_addr == ADDR_W'(OFS_CMD_SIZE))  word = BUF_SIZE;
        if (word_addr == ADDR_W'(OFS_CMD_ADDR))  word = BUF_ADDR;
        if (word_addr == ADDR_W'(OFS_RSP_SIZE))  word = BUF_SIZE;
        if (word_addr == ADDR_W'(OFS_RSP_ADDR))  word = BUF_ADDR;
    end

    // Byte-offset shift, gated by a read
    assign bus_rdata = (bus_sel && !bus_wr) ? (word >> {bus_addr[1:0], 3'b000}) : 32'h0;

endmodule

// File: rtl/crb_regif.sv
// Top: command-response buffer control register block. Ties the write
// decoder, control core, locality tracker and read path together.
// Assumes ADDR_W >= 8 and BUF_OFFSET < WINDOW_SIZE.
module crb_regif
    import crb_regif_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          ERR_W       = 8,
    parameter logic [31:0] BASE_ADDR   = 32'hFED40000,
    parameter logic [31:0] BUF_OFFSET  = 32'h80,
    parameter logic [31:0] WINDOW_SIZE = 32'h1000,
    parameter logic [15:0] VENDOR_ID   = 16'h1AB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_cmd_req,
    output logic              eng_cancel,
    input  logic              eng_done,
    input  logic [ERR_W-1:0]  eng_status
);

    localparam logic [31:0] BUF_SIZE = WINDOW_SIZE - BUF_OFFSET;
    localparam logic [31:0] BUF_ADDR = BASE_ADDR + BUF_OFFSET;

    wr_hit_t    hits;
    logic [31:0] wval;
    logic       idle_q;
    logic       fatal_q;
    logic       start_q;
    loc_flags_t flags;

    crb_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .hits      (hits),
        .wval      (wval)
    );

    crb_ctrl #(.ERR_W(ERR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hits       (hits),
        .wval       (wval),
        .eng_done   (eng_done),
        .eng_status (eng_status),
        .idle_q     (idle_q),
        .fatal_q    (fatal_q),
        .start_q    (start_q),
        .cmd_req_q  (eng_cmd_req),
        .cancel_q   (eng_cancel)
    );

    crb_loc u_loc (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .wval  (wval),
        .flags (flags)
    );

    crb_rd_mux #(
        .ADDR_W    (ADDR_W),
        .VENDOR_ID (VENDOR_ID),
        .BUF_SIZE  (BUF_SIZE),
        .BUF_ADDR  (BUF_ADDR)
    ) u_rd (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .idle_q    (idle_q),
        .fatal_q   (fatal_q),
        .start_q   (start_q),
        .flags     (flags),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/crb_regif_chk.sv
// Checker: temporal rules of the start/cancel/completion handshake.
// Attached to every crb_regif instance by the bind below.
module crb_regif_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_req,
    input logic             cancel,
    input logic             eng_done,
    input logic [ERR_W-1:0] eng_status,
    input logic             start_bit,
    input logic             fatal_bit,
    input logic             granted,
    input logic             seized
);

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    p_req_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_bit) |-> cmd_req);

    p_req_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> (start_bit && !$past(start_bit)));

    p_cancel_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> $past(start_bit));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && start_bit) |=> !start_bit);

    p_err_fatal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && start_bit && (eng_status != '0)) |=> fatal_bit);

    p_fatal_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_bit |=> fatal_bit);

    p_never_seized_r6: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> !seized);

endmodule

bind crb_regif crb_regif_chk #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_req    (eng_cmd_req),
    .cancel     (eng_cancel),
    .eng_done   (eng_done),
    .eng_status (eng_status),
    .start_bit  (start_q),
    .fatal_bit  (fatal_q),
    .granted    (flags.granted),
    .seized     (flags.seized)
);

// File: tb/crb_regif_bench.sv
module crb_regif_bench;

    localparam int          ADDR_W = 8;
    localparam int          ERR_W  = 8;
    localparam logic [31:0] BASE   = 32'hFED40000;
    localparam logic [31:0] BOFS   = 32'h80;
    localparam logic [31:0] WIN    = 32'h1000;
    localparam logic [15:0] VID    = 16'h1AB5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [3:0]        bus_be = 4'h0;
    logic [31:0]       bus_wdata = 32'h0;
    logic [31:0]       bus_rdata;
    logic              eng_cmd_req;
    logic              eng_cancel;
    logic              eng_done = 1'b0;
    logic [ERR_W-1:0]  eng_status = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model
    bit m_idle, m_start, m_fatal, m_loc;

    always #5 clk = ~clk;

    crb_regif #(
        .ADDR_W(ADDR_W), .ERR_W(ERR_W), .BASE_ADDR(BASE),
        .BUF_OFFSET(BOFS), .WINDOW_SIZE(WIN), .VENDOR_ID(VID)
    ) u_crb_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_cmd_req(eng_cmd_req),
        .eng_cancel(eng_cancel), .eng_done(eng_done), .eng_status(eng_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // expected aligned word from the model (R1, R6, R8, R9, R10)
    function automatic logic [31:0] exp_word(input logic [7:0] a);
        logic [7:0] w;
        w = {a[7:2], 2'b00};
        case (w)
            8'h00: return m_loc ? 32'h3 : 32'h0;
            8'h08: return m_loc ? 32'h1 : 32'h0;
            8'h10: return 32'h00025811;
            8'h14: return {16'h0, VID};
            8'h24: return {30'h0, m_idle, m_fatal};
            8'h2C: return {31'h0, m_start};
            8'h30, 8'h38: return WIN - BOFS;
            8'h34, 8'h3C: return BASE + BOFS;
            default: return 32'h0;
        endcase
    endfunction

    // R7: byte-offset shift
    function automatic logic [31:0] exp_read(input logic [7:0] a);
        return exp_word(a) >> (8 * a[1:0]);
    endfunction

    function automatic logic [31:0] mask_be(input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? d[8*i +: 8] : 8'h00;
        return r;
    endfunction

    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
        bus_sel = 1'b0;
    endtask

    // write, update model, check the pulses one cycle later (R2-R6, R10)
    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] v;
        bit exp_req, exp_can;
        v = mask_be(d, be);
        exp_req = 1'b0; exp_can = 1'b0;
        if (a[1:0] == 2'b00) begin
            case (a)
                8'h20: begin
                    if (v == 1) m_idle = 1'b0;
                    else if (v == 2) m_idle = 1'b1;
                end
                8'h2C: if (v == 1 && !m_start) begin m_start = 1'b1; exp_req = 1'b1; end
                8'h28: if (v == 1 && m_start) exp_can = 1'b1;
                8'h04: if (v == 1) m_loc = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
        check("R3 cmd_req pulse", {31'h0, eng_cmd_req}, {31'h0, exp_req});
        check("R4 cancel pulse", {31'h0, eng_cancel}, {31'h0, exp_can});
    endtask

    // completion strobe (R5)
    task automatic do_done(input logic [ERR_W-1:0] st);
        if (m_start) begin
            m_start = 1'b0;
            if (st != '0) m_fatal = 1'b1;
        end
        @(negedge clk);
        eng_done = 1'b1; eng_status = st;
        @(negedge clk);
        eng_done = 1'b0; eng_status = '0;
        #1;
        check("R5 no pulse on done", {30'h0, eng_cmd_req, eng_cancel}, 32'h0);
    endtask

    task automatic check_state();
        do_read(8'h24, "R2/R5 status");
        do_read(8'h2C, "R3 start bit");
        do_read(8'h08, "R6 loc status");
        do_read(8'h00, "R6 loc state");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] regs [13];
        regs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h20, 8'h24,
                 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C};
        void'($urandom(32'd20240611));
        m_idle = 1'b1; m_start = 1'b0; m_fatal = 1'b0; m_loc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 pulses low", {30'h0, eng_cmd_req, eng_cancel}, 32'h0);
        do_read(8'h24, "R1 status 0x2");
        check("R1 status literal", exp_word(8'h24), 32'h2);
        do_read(8'h2C, "R1 start clear");
        do_read(8'h00, "R1 loc state");
        do_read(8'h08, "R1 loc status");

        // R8, R9, R7 constants and shifts
        do_read(8'h10, "R8 id lo");
        do_read(8'h14, "R8 id hi");
        do_read(8'h11, "R7 byte1 of id");
        do_read(8'h13, "R7 byte3 of id");
        do_read(8'h30, "R9 cmd size");
        do_read(8'h3C, "R9 rsp addr");
        do_read(8'h36, "R7 half of cmd addr");
        do_read(8'h44, "R10 unlisted read");
        do_read(8'h20, "R10 write-only read");

        // R2 exact codes
        do_write(8'h20, 32'd3, 4'hF); do_read(8'h24, "R2 code 3 ignored");
        do_write(8'h20, 32'd1, 4'hF); do_read(8'h24, "R2 ready clears idle");
        do_write(8'h20, 32'h101, 4'hF); do_read(8'h24, "R2 0x101 ignored");
        do_write(8'h20, 32'd2, 4'hF); do_read(8'h24, "R2 go idle");

        // R4 cancel while idle, R5 stray done
        do_write(8'h28, 32'd1, 4'hF);
        do_done(8'h5); do_read(8'h24, "R5 stray done no fatal");

        // R10 byte enables and misaligned write
        do_write(8'h2C, 32'd1, 4'h0); do_read(8'h2C, "R10 be=0 start ignored");
        do_write(8'h2D, 32'h100, 4'hF); do_read(8'h2C, "R10 misaligned ignored");
        do_write(8'h2C, 32'hFFFF_FF01, 4'h1); do_read(8'h2C, "R10 masked start set");

        // R3 second start ignored, R4 cancel while busy
        do_write(8'h2C, 32'd1, 4'hF); do_read(8'h2C, "R3 still set");
        do_write(8'h28, 32'd1, 4'hF);
        do_done(8'h0); check_state();
        do_write(8'h2C, 32'd1, 4'hF);
        do_done(8'h3); do_read(8'h24, "R5 fatal set");

        // R6 ignored codes then claim
        do_write(8'h04, 32'd2, 4'hF); do_write(8'h04, 32'd8, 4'hF);
        do_read(8'h08, "R6 release ignored");
        do_write(8'h04, 32'd1, 4'hF); check_state();

        // random phase
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] val;
            logic [3:0]  be;
            op = $urandom_range(0, 5);
            case ($urandom_range(0, 4))
                0: val = 32'd1;
                1: val = 32'd2;
                2: val = 32'd3;
                3: val = 32'd8;
                default: val = $urandom;
            endcase
            be = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            case (op)
                0: do_write(8'h20, val, be);
                1: do_write(8'h2C, val, be);
                2: do_write(8'h28, val, be);
                3: do_done(($urandom_range(0, 3) == 0) ? ERR_W'($urandom) : '0);
                4: do_write(regs[$urandom_range(0, 12)], val, be);
                default: do_write(8'($urandom), val, be);
            endcase
            check_state();
            do_read(8'($urandom), "R7 random read");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule